// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block lets on-chip logic reach slow parallel devices such as flash, SRAM or memory-mapped peripherals. It serves four banks, and each bank has its own active-low chip select. An internal requester presents a bank number, a word offset, a read/write flag, up to four data words and byte strobes. The block then runs one external bus cycle. It drives address, chip select, output enable or write enable and byte enables, and it returns the data words when it raises a one-cycle acknowledge.

Every bank carries a timing word with six cycle counts. These set the address lead before chip select, the chip select lead before the strobe, the strobe (access) length, the chip select trail after the strobe, the address trail after chip select, and the length of each extra beat in page mode. A shared width word holds a small field per bank that selects an 8- or 16-bit data path and whether byte enables are used. The data pins appear as a split output, enable and input triple, so a pad ring can build the bidirectional bus.

Software programs the bank registers while the bus is idle. The configuration of the selected bank is captured when a request is accepted, so the register contents do not matter during a cycle.

Top module: `smb_ctrl`

## Requirements
- R1: After reset all chip selects, the read strobe, the write strobe and both byte enables are high. Acknowledge is low, the data output enable is low, and every register reads zero.
- R2: The register map is as follows. Offset 0x00 is the width word: bank n uses bits 4n+3..4n, with bit 4n = 16-bit path and bit 4n+1 = byte enables used. Bits 4n+3..4n+2 and bits 31..16 read zero. Offset 0x04+4n is bank n's timing word. Any other offset reads zero, and a write to it changes no register.
- R3: The timing word fields are: address lead [31:28], chip-select lead [27:24], access count [20:16], strobe trail [15:12], address trail [11:8], page beat length [7:4] and page enable [0]. All other bits read zero.
- R4: Take the cycle after the accepting edge as cycle 1. Chip select first goes low in cycle lead_a+1, and the strobe first goes low in cycle lead_a+lead_cs+1.
- R5: The first strobe-low stretch lasts access+1 cycles, so it is never empty.
- R6: Chip select stays low for lead_cs + (access+1) + page cycles + trail_cs cycles. Acknowledge is high for exactly one cycle, in cycle lead_a+lead_cs+access+1+page+trail_cs+trail_a+1.
- R7: With page enable set, three more beats follow the access phase, each max(beat length,1) cycles long, with chip select and strobe held low. Beat k drives the offset with its low two bits incremented by k modulo 4.
- R8: Read data is sampled in the last strobe cycle of each beat. Beat k is returned in rd_data[16k+15:16k]. An 8-bit bank returns the low byte zero-extended. Beats that were not run return zero.
- R9: A write uses the write strobe in place of the read strobe and never asserts the read strobe. The data output enable is high exactly while chip select is low, with the current beat's word from req_wdata[16k+15:16k]. Reads never enable the data output.
- R10: While the strobe is low on a bank with both the 16-bit path and byte enables set, the byte enables equal the inverted request strobes. At all other times they stay high.
- R11: Only the chip select of the requested bank ever goes low.
- R12: A request is taken only while idle. A request raised during a cycle is ignored: its bank is never selected and no extra acknowledge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW (5) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Access request |
| req_bank | input | BKW (2) | Target bank |
| req_ofs | input | OFS_W (16) | Word offset inside the bank |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | BEATS*DW (64) | Write words, beat k at [16k+15:16k] |
| req_be | input | DW/8 (2) | Byte strobes, active high |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | BEATS*DW (64) | Read words, beat k at [16k+15:16k] |
| mem_addr | output | OFS_W (16) | External address |
| mem_cs_n | output | NBANK (4) | Chip select per bank, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DW/8 (2) | Byte enables, active low |
| mem_dq_o | output | DW (16) | Data to pad |
| mem_dq_oe | output | 1 | Data pad output enable |
| mem_dq_i | input | DW (16) | Data from pad |

## Verification
Every pin is sampled on the falling edge, starting one cycle after the accepting edge. Each sample is numbered from that edge, so the first chip-select cycle, the first strobe cycle, the strobe and select durations and the acknowledge cycle are compared with sums of the programmed counts from R4 to R6. Read words are compared once acknowledge is seen, because they are registered in the last strobe cycle of each beat. Byte enables, data drive and beat addresses are compared in every sampled cycle against the expected beat index, which the bench derives from the strobe-cycle count.

// File: rtl/smb_pkg.sv
package smb_pkg;

    // Phases in the order an access walks through them.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ASET  = 3'd1,
        PH_CSET  = 3'd2,
        PH_ACC   = 3'd3,
        PH_PAGE  = 3'd4,
        PH_CHOLD = 3'd5,
        PH_AHOLD = 3'd6,
        PH_DONE  = 3'd7
    } phase_e;

    typedef struct packed {
        logic [3:0] lead_a;
        logic [3:0] lead_cs;
        logic [4:0] acc;
        logic [3:0] trail_cs;
        logic [3:0] trail_a;
        logic [3:0] beat_len;
        logic       page;
    } tcfg_t;

    localparam logic [31:0] TIM_MASK = 32'hFF1F_FFF1;
    localparam logic [3:0]  BW_FIELD = 4'h3;

    function automatic tcfg_t decode_tim(input logic [31:0] r);
        tcfg_t t;
        t.lead_a   = r[31:28];
        t.lead_cs  = r[27:24];
        t.acc      = r[20:16];
        t.trail_cs = r[15:12];
        t.trail_a  = r[11:8];
        t.beat_len = r[7:4];
        t.page     = r[0];
        return t;
    endfunction

    // Cycles spent in a phase; zero means the phase is skipped.
    function automatic logic [5:0] phase_len(input phase_e p, input tcfg_t t);
        case (p)
            PH_ASET:  return {2'b00, t.lead_a};
            PH_CSET:  return {2'b00, t.lead_cs};
            PH_ACC:   return {1'b0, t.acc} + 6'd1;
            PH_PAGE:  return t.page ? ((t.beat_len == 4'd0) ? 6'd1 : {2'b00, t.beat_len}) : 6'd0;
            PH_CHOLD: return {2'b00, t.trail_cs};
            PH_AHOLD: return {2'b00, t.trail_a};
            PH_DONE:  return 6'd1;
            default:  return 6'd0;
        endcase
    endfunction

    // First phase after 'from' that lasts at least one cycle.
    function automatic phase_e next_live(input phase_e from, input tcfg_t t);
        phase_e p;
        logic   found;
        p     = from;
        found = 1'b0;
        for (int i = 0; i < 7; i++) begin
            if (!found && p != PH_DONE) begin
                p = phase_e'(p + 3'd1);
                if (phase_len(p, t) != 6'd0) found = 1'b1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/smb_regs.sv
module smb_regs
    import smb_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int RAW   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [RAW-1:0]        addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic [NBANK*4-1:0]    bw,
    output logic [NBANK-1:0][31:0] tim
);
    localparam int BWW = NBANK * 4;
    localparam logic [BWW-1:0] BW_MASK = {NBANK{BW_FIELD}};

    typedef struct packed {
        logic [BWW-1:0]        bw;
        logic [NBANK-1:0][31:0] tim;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        rdata = '0;
        if (addr == '0) rdata = 32'(q.bw);
        for (int n = 0; n < NBANK; n++) begin
            if (addr == RAW'(4 * (n + 1))) rdata = q.tim[n];
        end
        if (wr_en) begin
            if (addr == '0) d.bw = wdata[BWW-1:0] & BW_MASK;
            for (int n = 0; n < NBANK; n++) begin
                if (addr == RAW'(4 * (n + 1))) d.tim[n] = wdata & TIM_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bw  = q.bw;
    assign tim = q.tim;

    // R2: width word never shows bits outside the per-bank fields
    p_bw_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> ((rdata & ~32'(BW_MASK)) == 32'd0));

    // R3: a timing word write lands with its reserved bits cleared
    p_tim_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RAW'(4)) |=> ((tim[0] & ~TIM_MASK) == 32'd0));

endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int OFS_W = 16,
    parameter int DW    = 16,
    parameter int BEATS = 4,
    parameter int BKW   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [BKW-1:0]        req_bank,
    input  logic [OFS_W-1:0]      req_ofs,
    input  logic                  req_wr,
    input  logic [BEATS*DW-1:0]   req_wdata,
    input  logic [DW/8-1:0]       req_be,
    input  tcfg_t                 cfg_in,
    input  logic                  w16_in,
    input  logic                  been_in,
    output logic                  ack,
    output logic [BEATS*DW-1:0]   rd_data,
    output logic [OFS_W-1:0]      mem_addr,
    output logic [NBANK-1:0]      mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DW/8-1:0]       mem_be_n,
    output logic [DW-1:0]         mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DW-1:0]         mem_dq_i
);
    localparam int BL  = DW / 8;
    localparam int BTW = $clog2(BEATS);

    typedef struct packed {
        phase_e              ph;
        logic [5:0]          cnt;
        logic [BTW-1:0]      beat;
        logic [BKW-1:0]      bank;
        logic [OFS_W-1:0]    ofs;
        logic                wr;
        logic [BEATS*DW-1:0] wdata;
        logic [BL-1:0]       be;
        tcfg_t               t;
        logic                w16;
        logic                been;
        logic [BEATS*DW-1:0] rdata;
    } st_t;

    st_t  q, d;
    logic beat_end;
    logic cs_win;
    logic strobe;

    always_comb begin
        d        = q;
        beat_end = (q.ph == PH_ACC || q.ph == PH_PAGE) && q.cnt == 6'd1;
        if (beat_end && !q.wr) begin
            d.rdata[q.beat*DW +: DW] = q.w16 ? mem_dq_i : {{(DW-8){1'b0}}, mem_dq_i[7:0]};
        end
        case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    d.bank  = req_bank;
                    d.ofs   = req_ofs;
                    d.wr    = req_wr;
                    d.wdata = req_wdata;
                    d.be    = req_be;
                    d.t     = cfg_in;
                    d.w16   = w16_in;
                    d.been  = been_in;
                    d.rdata = '0;
                    d.beat  = '0;
                    d.ph    = next_live(PH_IDLE, cfg_in);
                    d.cnt   = phase_len(d.ph, cfg_in);
                end
            end
            PH_DONE: d.ph = PH_IDLE;
            default: begin
                if (q.cnt == 6'd1) begin
                    if (q.ph == PH_PAGE && q.beat != BTW'(BEATS - 1)) begin
                        d.beat = q.beat + 1'b1;
                        d.cnt  = phase_len(PH_PAGE, q.t);
                    end else begin
                        d.ph  = next_live(q.ph, q.t);
                        d.cnt = phase_len(d.ph, q.t);
                        if (d.ph == PH_PAGE) d.beat = BTW'(1);
                    end
                end else begin
                    d.cnt = q.cnt - 6'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_win = (q.ph == PH_CSET) || (q.ph == PH_ACC) ||
                    (q.ph == PH_PAGE) || (q.ph == PH_CHOLD);
    assign strobe = (q.ph == PH_ACC) || (q.ph == PH_PAGE);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_cs
            assign mem_cs_n[b] = !(cs_win && q.bank == BKW'(b));
        end
    endgenerate

    assign mem_oe_n  = !(strobe && !q.wr);
    assign mem_we_n  = !(strobe && q.wr);
    assign mem_be_n  = (strobe && q.w16 && q.been) ? ~q.be : '1;
    assign mem_addr  = {q.ofs[OFS_W-1:BTW], q.ofs[BTW-1:0] + q.beat};
    assign mem_dq_oe = cs_win && q.wr;
    assign mem_dq_o  = q.wdata[q.beat*DW +: DW];
    assign ack       = (q.ph == PH_DONE);
    assign rd_data   = q.rdata;

    // R11: at most one bank selected at any time
    p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R4: a strobe is only ever inside a chip-select window
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

    // R9: read and write strobes never overlap; data drive only under chip select
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_dq_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_cs_n != '1));

    // R10: byte enables quiet whenever no strobe is active
    p_be_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n && mem_we_n) |-> (mem_be_n == '1));

    // R12: acknowledge is a single pulse; the bank stays put while busy
    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_bank_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE) |=> $stable(q.bank));

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int OFS_W = 16,
    parameter int DW    = 16,
    parameter int BEATS = 4,
    parameter int BKW   = $clog2(NBANK),
    parameter int RAW   = $clog2(4 * (NBANK + 1))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [RAW-1:0]        reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  req_valid,
    input  logic [BKW-1:0]        req_bank,
    input  logic [OFS_W-1:0]      req_ofs,
    input  logic                  req_wr,
    input  logic [BEATS*DW-1:0]   req_wdata,
    input  logic [DW/8-1:0]       req_be,
    output logic                  ack,
    output logic [BEATS*DW-1:0]   rd_data,
    output logic [OFS_W-1:0]      mem_addr,
    output logic [NBANK-1:0]      mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DW/8-1:0]       mem_be_n,
    output logic [DW-1:0]         mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DW-1:0]         mem_dq_i
);
    logic [NBANK*4-1:0]     bw;
    logic [NBANK-1:0][31:0] tim;
    tcfg_t                  cfg_sel;
    logic [1:0]             bw_sel;

    smb_regs #(.NBANK(NBANK), .RAW(RAW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .bw    (bw),
        .tim   (tim)
    );

    always_comb begin
        cfg_sel = decode_tim(tim[req_bank]);
        bw_sel  = bw[req_bank*4 +: 2];
    end

    smb_seq #(
        .NBANK(NBANK), .OFS_W(OFS_W), .DW(DW), .BEATS(BEATS), .BKW(BKW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_ofs   (req_ofs),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .cfg_in    (cfg_sel),
        .w16_in    (bw_sel[0]),
        .been_in   (bw_sel[1]),
        .ack       (ack),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

endmodule

// File: tb/sim_smb_ctrl.sv
module sim_smb_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_ofs = '0;
    logic        req_wr = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack;
    logic [63:0] rd_data;
    logic [15:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    always #5 clk = ~clk;

    function automatic logic [15:0] rdval(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3};
    endfunction

    assign mem_dq_i = (!mem_oe_n) ? rdval(mem_addr) : 16'h0000;

    smb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_bank(req_bank), .req_ofs(req_ofs), .req_wr(req_wr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // bank, lead_a, lead_cs, acc, trail_cs, trail_a, beat_len, page, w16, been, wr, ofs, be
    typedef struct packed {
        logic [1:0]  bank;
        logic [3:0]  lead_a, lead_cs;
        logic [4:0]  acc;
        logic [3:0]  trail_cs, trail_a, beat_len;
        logic        page, w16, been, wr;
        logic [15:0] ofs;
        logic [1:0]  be;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd1,  4'd2,  5'd3,  4'd1,  4'd2,  4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0012, 2'b11},
        '{2'd1, 4'd0,  4'd0,  5'd0,  4'd0,  4'd0,  4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 16'h0100, 2'b01},
        '{2'd2, 4'd2,  4'd1,  5'd4,  4'd2,  4'd1,  4'd2,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0206, 2'b11},
        '{2'd3, 4'd3,  4'd0,  5'd1,  4'd0,  4'd3,  4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 16'h0301, 2'b10},
        '{2'd3, 4'd15, 4'd15, 5'd31, 4'd15, 4'd15, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFE, 2'b11},
        '{2'd1, 4'd0,  4'd4,  5'd0,  4'd3,  4'd0,  4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 16'h0042, 2'b11}
    };

    logic [31:0] bw_shadow = '0;

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] timv, rb;
        logic [63:0] wd, exp_rd;
        int tp, pg, k, lat, first_cs, first_st, cs_cnt, st_cnt;
        int cs_bad, other_st, be_bad, dq_bad, beat_bad, eb, db;
        bit got;
        logic [1:0] exp_be;
        logic [15:0] a, w;
        timv = {v.lead_a, v.lead_cs, 3'b000, v.acc, v.trail_cs, v.trail_a, v.beat_len, 3'b000, v.page};
        reg_write(5'(4 * (v.bank + 1)), timv);
        reg_read(5'(4 * (v.bank + 1)), rb);
        chk(rb == timv, $sformatf("R3 timing readback vec%0d", idx), 64'(rb), 64'(timv));
        bw_shadow[v.bank*4 +: 4] = {2'b00, v.been, v.w16};
        reg_write(5'h00, bw_shadow);
        for (int b = 0; b < 4; b++) wd[b*16 +: 16] = 16'(16'h1234 * (b + 1)) ^ 16'(idx * 16'h0101);
        tp = (v.beat_len == 0) ? 1 : int'(v.beat_len);
        pg = v.page ? 3 * tp : 0;
        exp_be = (v.w16 && v.been) ? ~v.be : 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_bank = v.bank; req_ofs = v.ofs; req_wr = v.wr;
        req_wdata = wd; req_be = v.be;
        k = 0; got = 0; lat = 0; first_cs = 0; first_st = 0; cs_cnt = 0; st_cnt = 0;
        cs_bad = 0; other_st = 0; be_bad = 0; dq_bad = 0; beat_bad = 0;
        while (!got && k < 400) begin
            @(negedge clk);
            req_valid = 1'b0;
            k++;
            if (mem_cs_n != 4'hF) begin
                if (first_cs == 0) first_cs = k;
                cs_cnt++;
                if (mem_cs_n != ~(4'b0001 << v.bank)) cs_bad++;
            end
            if ((v.wr ? mem_oe_n : mem_we_n) == 1'b0) other_st++;
            if ((v.wr ? mem_we_n : mem_oe_n) == 1'b0) begin
                if (first_st == 0) first_st = k;
                eb = (st_cnt <= int'(v.acc)) ? 0 : 1 + (st_cnt - int'(v.acc) - 1) / tp;
                db = int'(2'(mem_addr[1:0] - v.ofs[1:0]));
                if (db != eb || mem_addr[15:2] != v.ofs[15:2]) beat_bad++;
                if (mem_be_n != exp_be) be_bad++;
                if (v.wr && mem_dq_o != wd[eb*16 +: 16]) dq_bad++;
                st_cnt++;
            end else if (mem_be_n != 2'b11) be_bad++;
            if (mem_dq_oe != (v.wr && mem_cs_n != 4'hF)) dq_bad++;
            if (ack) begin got = 1; lat = k; end
        end
        chk(got && lat == int'(v.lead_a) + int'(v.lead_cs) + int'(v.acc) + 1 + pg + int'(v.trail_cs) + int'(v.trail_a) + 1,
            $sformatf("R6 ack cycle vec%0d", idx), 64'(lat),
            64'(int'(v.lead_a) + int'(v.lead_cs) + int'(v.acc) + 2 + pg + int'(v.trail_cs) + int'(v.trail_a)));
        chk(first_cs == int'(v.lead_a) + 1, $sformatf("R4 first select cycle vec%0d", idx), 64'(first_cs), 64'(int'(v.lead_a) + 1));
        chk(first_st == int'(v.lead_a) + int'(v.lead_cs) + 1, $sformatf("R4 first strobe cycle vec%0d", idx),
            64'(first_st), 64'(int'(v.lead_a) + int'(v.lead_cs) + 1));
        chk(st_cnt == int'(v.acc) + 1 + pg, $sformatf("R5 R7 strobe cycles vec%0d", idx), 64'(st_cnt), 64'(int'(v.acc) + 1 + pg));
        chk(cs_cnt == int'(v.lead_cs) + int'(v.acc) + 1 + pg + int'(v.trail_cs), $sformatf("R6 select cycles vec%0d", idx),
            64'(cs_cnt), 64'(int'(v.lead_cs) + int'(v.acc) + 1 + pg + int'(v.trail_cs)));
        chk(cs_bad == 0, $sformatf("R11 wrong select vec%0d", idx), 64'(cs_bad), 64'd0);
        chk(beat_bad == 0, $sformatf("R7 beat address vec%0d", idx), 64'(beat_bad), 64'd0);
        chk(be_bad == 0, $sformatf("R10 byte enables vec%0d", idx), 64'(be_bad), 64'd0);
        chk(dq_bad == 0 && other_st == 0, $sformatf("R9 data drive and strobe vec%0d", idx), 64'(dq_bad + other_st), 64'd0);
        exp_rd = '0;
        if (!v.wr) begin
            for (int b = 0; b < 4; b++) begin
                if (b == 0 || v.page) begin
                    a = {v.ofs[15:2], 2'(v.ofs[1:0] + 2'(b))};
                    w = rdval(a);
                    if (!v.w16) w[15:8] = 8'h00;
                    exp_rd[b*16 +: 16] = w;
                end
            end
        end
        chk(rd_data == exp_rd, $sformatf("R8 read words vec%0d", idx), rd_data, exp_rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int acks, bad2, k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle pins and zero registers after reset
        chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && mem_be_n == 2'b11, "R1 idle pins",
            {58'd0, mem_cs_n, mem_oe_n, mem_we_n}, 64'h3F);
        chk(!ack && !mem_dq_oe, "R1 ack and data enable low", {62'd0, ack, mem_dq_oe}, 64'd0);
        for (int i = 0; i < 5; i++) begin
            reg_read(5'(4 * i), rv);
            chk(rv == 32'd0, $sformatf("R1 register %0d after reset", i), 64'(rv), 64'd0);
        end

        // R2/R3 register map and reserved bits
        reg_write(5'h00, 32'hFFFF_FFFF);
        reg_read(5'h00, rv);
        chk(rv == 32'h0000_3333, "R2 width word reserved bits", 64'(rv), 64'h3333);
        reg_write(5'h04, 32'hFFFF_FFFF);
        reg_read(5'h04, rv);
        chk(rv == 32'hFF1F_FFF1, "R3 timing word reserved bits", 64'(rv), 64'hFF1FFFF1);
        reg_write(5'h14, 32'hA5A5_A5A5);
        reg_write(5'h06, 32'h5A5A_5A5A);
        reg_read(5'h14, rv);
        chk(rv == 32'd0, "R2 unmapped offset reads zero", 64'(rv), 64'd0);
        reg_read(5'h04, rv);
        chk(rv == 32'hFF1F_FFF1, "R2 unmapped write leaves bank0 timing", 64'(rv), 64'hFF1FFFF1);
        reg_read(5'h08, rv);
        chk(rv == 32'd0, "R2 unmapped write leaves bank1 timing", 64'(rv), 64'd0);
        reg_write(5'h00, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R12: second request during a busy cycle is ignored
        reg_write(5'h04, {4'd1, 4'd1, 3'b000, 5'd8, 4'd1, 4'd1, 4'd0, 4'd0});
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'd0; req_ofs = 16'h0010; req_wr = 1'b0; req_be = 2'b11;
        acks = 0; bad2 = 0;
        for (k = 1; k <= 20; k++) begin
            @(negedge clk);
            req_valid = (k >= 3 && k < 5);
            if (k >= 3) req_bank = 2'd2;
            if (ack) acks++;
            if (mem_cs_n[2] == 1'b0) bad2++;
            if (k == 14) chk(ack == 1'b1, "R12 first request completes on time", 64'(ack), 64'd1);
        end
        chk(acks == 1, "R12 single acknowledge", 64'(acks), 64'd1);
        chk(bad2 == 0, "R12 busy request never selects its bank", 64'(bad2), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule